// File: doc/BRIEF.md
# Link Speed-Change Stall Recovery Monitor

This block runs one judgement on request, after a link has reached its active state and a move to the second-generation signalling rate has been started. A training move of that kind can hang when the training state machine sits in its receiver-lock step of recovery while the PHY receiver reports no valid data. The monitor first waits a settling interval, which by default is about 2 ms at 125 MHz. It then looks at two debug words from the controller and at a status register inside the PHY. If it finds the hung condition, it forces two receiver override bits on, keeps them on for a hold interval, and then removes them.

The PHY registers are 16 bits wide and are reached indirectly through a simple request/acknowledge port. Another block turns that port into the PHY's own handshake. The monitor never rewrites an override register blindly. Both changes read the register first, modify only the two override bits, and write the result back. Every other field of that register keeps the value the PHY currently holds.

Top module: `spdchg_stall_recover`

## Requirements
- R1: After reset, `busy`, `recovered` and `reg_req` are all low.
- R2: A `chk_req` pulse while idle raises `busy` in the next cycle. No register access is issued until at least `SETTLE_CYC` cycles have passed. `busy` falls when the judgement or the recovery is complete.
- R3: If bit 4 of `dbg_hi` (link-up, overall debug bit 36) is 1 when the settle interval ends, the monitor makes no register access and returns to idle.
- R4: Otherwise the monitor reads PHY address 0x100D exactly once. If bit 0 of that value (receiver valid) is 1, no write follows.
- R5: The training state is `dbg_lo[5:0]`. Recovery starts only if that field equals 0x0D and receiver valid is 0. Bits above bit 5 of `dbg_lo` have no effect.
- R6: Recovery reads PHY address 0x1005 and writes back the value read with bits 5 and 3 set (OR with 0x0028). All other bits are kept.
- R7: At least `HOLD_CYC` cycles pass between the acknowledge of the setting write and the next request to address 0x1005.
- R8: After the hold, the monitor reads 0x1005 again and writes back that fresh value with bits 5 and 3 cleared (AND with 0xFFD7). All other bits are kept.
- R9: `recovered` is high for exactly one cycle, the cycle after the clearing write is acknowledged, and `busy` is low in that cycle. A judgement that ends without recovery never raises `recovered`.
- R10: While `reg_req` is high and not yet acknowledged, `reg_wr`, `reg_addr` and `reg_wdata` hold steady. A request is complete in the cycle `reg_ack` is high. Every write is to 0x1005.
- R11: `chk_req` while `busy` is high is ignored and starts no second judgement.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chk_req | input | 1 | Start one judgement (single-cycle pulse) |
| dbg_lo | input | 32 | Lower debug word; bits 5:0 are the training state |
| dbg_hi | input | 32 | Upper debug word; bit 4 is link-up |
| reg_req | output | 1 | PHY register access request |
| reg_wr | output | 1 | 1 = write, 0 = read |
| reg_addr | output | 16 | PHY register address |
| reg_wdata | output | 16 | Write data |
| reg_ack | input | 1 | Access complete; read data valid |
| reg_rdata | input | 16 | Read data |
| busy | output | 1 | High while a judgement or recovery is in progress |
| recovered | output | 1 | One-cycle pulse when a recovery sequence ends |

## Verification
The bench changes the override register between the two read-modify-write passes. A design that reused the first value read for the second write would therefore write stale bits, and the comparison on the second write value would catch it. It drives the stall code with unrelated upper bits set in the state word. It also drives the other upper-word bits with link-up clear. A design that compared the whole word, or took link-up from the wrong bit, would then judge the case wrongly. The bench measures the settle and hold windows in clock cycles, which exposes a design that skips or shortens either wait. It sends a second start pulse mid-judgement, which exposes a design that starts a duplicate sequence or issues extra accesses.

// File: rtl/srm_pkg.sv
package srm_pkg;

    localparam int DBG_W       = 32;
    localparam int REG_AW      = 16;
    localparam int REG_DW      = 16;
    localparam int STATE_W     = 6;
    localparam int LINKUP_BIT  = 4;
    localparam int RXVALID_BIT = 0;
    localparam int DATA_EN_BIT = 5;
    localparam int PLL_EN_BIT  = 3;

    localparam logic [STATE_W-1:0] STALL_CODE = 6'h0D;
    localparam logic [REG_AW-1:0]  STAT_ADDR  = 16'h100D;
    localparam logic [REG_AW-1:0]  OVR_ADDR   = 16'h1005;
    localparam logic [REG_DW-1:0]  OVR_MASK   =
        REG_DW'((1 << DATA_EN_BIT) | (1 << PLL_EN_BIT));

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETTLE,
        ST_STAT_RD,
        ST_OVR_RD,
        ST_OVR_SET,
        ST_HOLD,
        ST_OVR_RD2,
        ST_OVR_CLR
    } srm_state_e;

    typedef struct packed {
        logic              req;
        logic              wr;
        logic [REG_AW-1:0] addr;
    } reg_cmd_t;

    function automatic logic [REG_DW-1:0] ovr_force(input logic [REG_DW-1:0] v);
        return v | OVR_MASK;
    endfunction

    function automatic logic [REG_DW-1:0] ovr_release(input logic [REG_DW-1:0] v);
        return v & ~OVR_MASK;
    endfunction

    function automatic reg_cmd_t cmd_for(input srm_state_e s);
        reg_cmd_t c;
        c = '{req: 1'b0, wr: 1'b0, addr: '0};
        unique case (s)
            ST_STAT_RD: c = '{req: 1'b1, wr: 1'b0, addr: STAT_ADDR};
            ST_OVR_RD,
            ST_OVR_RD2: c = '{req: 1'b1, wr: 1'b0, addr: OVR_ADDR};
            ST_OVR_SET,
            ST_OVR_CLR: c = '{req: 1'b1, wr: 1'b1, addr: OVR_ADDR};
            default:    c = '{req: 1'b0, wr: 1'b0, addr: '0};
        endcase
        return c;
    endfunction

endpackage

// File: rtl/srm_timer.sv
module srm_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/srm_judge.sv
module srm_judge
    import srm_pkg::*;
(
    input  logic [DBG_W-1:0]  dbg_lo,
    input  logic [DBG_W-1:0]  dbg_hi,
    input  logic [REG_DW-1:0] stat_word,
    output logic              link_up,
    output logic              state_match,
    output logic              rx_valid
);
    logic [STATE_W-1:0] train_state;
    logic               judge_unused;

    assign train_state = dbg_lo[STATE_W-1:0];
    assign link_up     = dbg_hi[LINKUP_BIT];
    assign state_match = (train_state == STALL_CODE);
    assign rx_valid    = stat_word[RXVALID_BIT];

    assign judge_unused = ^(dbg_lo >> STATE_W)
                        ^ ^(dbg_hi & ~(DBG_W'(1) << LINKUP_BIT))
                        ^ ^(stat_word & ~(REG_DW'(1) << RXVALID_BIT));
endmodule

// File: rtl/spdchg_stall_recover.sv
module spdchg_stall_recover
    import srm_pkg::*;
#(
    parameter int SETTLE_CYC = 250000,
    parameter int HOLD_CYC   = 312500
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              chk_req,
    input  logic [DBG_W-1:0]  dbg_lo,
    input  logic [DBG_W-1:0]  dbg_hi,
    output logic              reg_req,
    output logic              reg_wr,
    output logic [REG_AW-1:0] reg_addr,
    output logic [REG_DW-1:0] reg_wdata,
    input  logic              reg_ack,
    input  logic [REG_DW-1:0] reg_rdata,
    output logic              busy,
    output logic              recovered
);
    localparam int MAX_CYC = (SETTLE_CYC > HOLD_CYC) ? SETTLE_CYC : HOLD_CYC;
    localparam int CNT_W   = $clog2(MAX_CYC + 1) + 1;

    srm_state_e        state_q, state_d;
    logic [REG_DW-1:0] data_q;
    logic              recovered_q;
    reg_cmd_t          cmd;
    logic              acked;
    logic              tmr_load, tmr_expired;
    logic [CNT_W-1:0]  tmr_val;
    logic              link_up, state_match, rx_valid;

    assign cmd       = cmd_for(state_q);
    assign reg_req   = cmd.req;
    assign reg_wr    = cmd.wr;
    assign reg_addr  = cmd.addr;
    assign reg_wdata = data_q;
    assign acked     = cmd.req && reg_ack;
    assign busy      = (state_q != ST_IDLE);
    assign recovered = recovered_q;

    srm_judge u_judge (
        .dbg_lo      (dbg_lo),
        .dbg_hi      (dbg_hi),
        .stat_word   (reg_rdata),
        .link_up     (link_up),
        .state_match (state_match),
        .rx_valid    (rx_valid)
    );

    // one timer serves both the settle wait and the override hold
    assign tmr_load = ((state_q == ST_IDLE) && chk_req) ||
                      ((state_q == ST_OVR_SET) && acked);
    assign tmr_val  = (state_q == ST_IDLE) ? CNT_W'(SETTLE_CYC) : CNT_W'(HOLD_CYC);

    srm_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (chk_req) state_d = ST_SETTLE;
            ST_SETTLE:  if (tmr_expired) state_d = link_up ? ST_IDLE : ST_STAT_RD;
            ST_STAT_RD: if (acked) state_d = (rx_valid || !state_match) ? ST_IDLE : ST_OVR_RD;
            ST_OVR_RD:  if (acked) state_d = ST_OVR_SET;
            ST_OVR_SET: if (acked) state_d = ST_HOLD;
            ST_HOLD:    if (tmr_expired) state_d = ST_OVR_RD2;
            ST_OVR_RD2: if (acked) state_d = ST_OVR_CLR;
            ST_OVR_CLR: if (acked) state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_IDLE;
            data_q      <= '0;
            recovered_q <= 1'b0;
        end else begin
            state_q     <= state_d;
            recovered_q <= (state_q == ST_OVR_CLR) && acked;
            if (acked && (state_q == ST_OVR_RD)) begin
                data_q <= ovr_force(reg_rdata);
            end else if (acked && (state_q == ST_OVR_RD2)) begin
                data_q <= ovr_release(reg_rdata);
            end
        end
    end
endmodule

// File: rtl/srm_checker.sv
module srm_checker
    import srm_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              reg_req,
    input logic              reg_wr,
    input logic [REG_AW-1:0] reg_addr,
    input logic [REG_DW-1:0] reg_wdata,
    input logic              reg_ack,
    input logic              busy,
    input logic              recovered
);
    a_r10_req_hold: assert property (@(posedge clk) disable iff (rst)
        (reg_req && !reg_ack) |=> (reg_req && $stable(reg_wr) &&
                                   $stable(reg_addr) && $stable(reg_wdata)));

    a_r10_write_addr: assert property (@(posedge clk) disable iff (rst)
        (reg_req && reg_wr) |-> (reg_addr == OVR_ADDR));

    a_r2_req_when_busy: assert property (@(posedge clk) disable iff (rst)
        reg_req |-> busy);

    a_r9_single_pulse: assert property (@(posedge clk) disable iff (rst)
        recovered |=> !recovered);

    a_r9_idle_on_pulse: assert property (@(posedge clk) disable iff (rst)
        recovered |-> !busy);

    a_r9_after_write: assert property (@(posedge clk) disable iff (rst)
        recovered |-> $past(reg_req && reg_wr && reg_ack));
endmodule

bind spdchg_stall_recover srm_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_req   (reg_req),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_ack   (reg_ack),
    .busy      (busy),
    .recovered (recovered)
);

// File: tb/spdchg_stall_recover_tb_top.sv
module spdchg_stall_recover_tb_top;
    localparam int S = 40;
    localparam int H = 60;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        chk_req = 1'b0;
    logic [31:0] dbg_lo = '0;
    logic [31:0] dbg_hi = '0;
    logic        reg_req, reg_wr, busy, recovered;
    logic [15:0] reg_addr, reg_wdata;
    logic        reg_ack = 1'b0;
    logic [15:0] reg_rdata = '0;

    int n_checks = 0;
    int n_errors = 0;
    int cyc = 0;

    logic [15:0] stat_model, ovr_model, flip_model;
    int n_stat_rd, n_ovr_rd, n_wr, n_rec, first_req_cyc, w1_cyc, rd2_cyc;
    logic [15:0] w1_val, w2_val;

    spdchg_stall_recover #(.SETTLE_CYC(S), .HOLD_CYC(H)) dut_i (
        .clk(clk), .rst(rst), .chk_req(chk_req), .dbg_lo(dbg_lo), .dbg_hi(dbg_hi),
        .reg_req(reg_req), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_ack(reg_ack), .reg_rdata(reg_rdata), .busy(busy), .recovered(recovered)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string rq, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", rq, act, exp);
        end
    endtask

    // register file responder with random latency
    initial begin
        forever begin
            @(negedge clk);
            if (reg_req) begin
                automatic logic        wr   = reg_wr;
                automatic logic [15:0] addr = reg_addr;
                automatic logic [15:0] wd   = reg_wdata;
                automatic int          lat  = $urandom_range(0, 4);
                if (n_stat_rd == 0 && n_ovr_rd == 0 && n_wr == 0) first_req_cyc = cyc;
                if (!wr && addr == 16'h1005 && n_wr == 1) rd2_cyc = cyc;
                repeat (lat) @(negedge clk);
                if (wr) begin
                    n_wr++;
                    if (n_wr == 1) begin w1_val = wd; w1_cyc = cyc; end
                    else w2_val = wd;
                    if (addr == 16'h1005) ovr_model = wd ^ ((n_wr == 1) ? flip_model : 16'h0);
                    reg_rdata = 16'h0;
                end else if (addr == 16'h100D) begin
                    n_stat_rd++;
                    reg_rdata = stat_model;
                end else if (addr == 16'h1005) begin
                    n_ovr_rd++;
                    reg_rdata = ovr_model;
                end else begin
                    reg_rdata = 16'hDEAD;
                end
                reg_ack = 1'b1;
                @(negedge clk);
                reg_ack = 1'b0;
            end
        end
    end

    initial begin
        forever begin
            @(negedge clk);
            if (recovered) begin
                n_rec++;
                check(!busy, "R9 busy low during recovered", int'(busy), 0);
            end
        end
    end

    task automatic run_case(input logic [31:0] lo, input logic [31:0] hi,
                            input logic [15:0] stat, input logic [15:0] ovr,
                            input logic [15:0] flip, input bit dup);
        bit recov, link;
        int base_stat;
        n_stat_rd = 0; n_ovr_rd = 0; n_wr = 0; n_rec = 0;
        first_req_cyc = 0; w1_cyc = 0; rd2_cyc = 0; w1_val = 0; w2_val = 0;
        stat_model = stat; ovr_model = ovr; flip_model = flip;
        dbg_lo = lo; dbg_hi = hi;
        link  = hi[4];
        recov = !link && !stat[0] && (lo[5:0] == 6'h0D);
        @(negedge clk);
        chk_req = 1'b1;
        begin
            automatic int c0 = cyc;
            @(negedge clk);
            chk_req = 1'b0;
            check(busy == 1'b1, "R2 busy after start", int'(busy), 1);
            if (dup) begin
                repeat (5) @(negedge clk);
                chk_req = 1'b1;
                @(negedge clk);
                chk_req = 1'b0;
            end
            for (int i = 0; i < 3000 && busy; i++) @(negedge clk);
            repeat (3) @(negedge clk);
            check(!busy, "R2 busy falls at end", int'(busy), 0);
            check(n_stat_rd == (link ? 0 : 1), "R3/R4 status reads", n_stat_rd, link ? 0 : 1);
            check(n_wr == (recov ? 2 : 0), "R5 write count", n_wr, recov ? 2 : 0);
            check(n_ovr_rd == (recov ? 2 : 0), "R6 override reads", n_ovr_rd, recov ? 2 : 0);
            check(n_rec == (recov ? 1 : 0), "R9 recovered pulses", n_rec, recov ? 1 : 0);
            if (!link) begin
                automatic int d = first_req_cyc - c0;
                check(d >= S + 1 && d <= S + 4, "R2 settle window", d, S + 2);
            end
            if (recov) begin
                automatic int d = rd2_cyc - w1_cyc;
                automatic logic [15:0] e1 = ovr | 16'h0028;
                automatic logic [15:0] e2 = (e1 ^ flip) & 16'hFFD7;
                check(w1_val == e1, "R6 first write value", w1_val, e1);
                check(d >= H + 1 && d <= H + 4, "R7 hold window", d, H + 2);
                check(w2_val == e2, "R8 second write value", w2_val, e2);
            end
            if (dup) begin
                base_stat = n_stat_rd;
                repeat (S + 20) @(negedge clk);
                check(n_stat_rd == base_stat && !busy, "R11 no second judgement",
                      n_stat_rd, base_stat);
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        n_stat_rd = 0; n_ovr_rd = 0; n_wr = 0; n_rec = 0;
        stat_model = 0; ovr_model = 0; flip_model = 0;
        repeat (4) @(negedge clk);
        check(!busy && !recovered && !reg_req, "R1 reset state",
              {busy, recovered, reg_req}, 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        check(!busy && !reg_req, "R1 idle after reset", {busy, reg_req}, 0);

        // R3 link up: no access
        run_case(32'h0000_000D, 32'h0000_0010, 16'h0000, 16'h1234, 16'h0, 1'b0);
        // R4 receiver valid: read only
        run_case(32'h0000_000D, 32'h0000_0000, 16'h0001, 16'h1234, 16'h0, 1'b0);
        // R5 other state: read only
        run_case(32'h0000_000C, 32'h0000_0000, 16'h0000, 16'h1234, 16'h0, 1'b0);
        // R5 stall with upper state bits set and other hi bits set
        run_case(32'hFFFF_FFCD, 32'hFFFF_FFEF, 16'hFFFE, 16'h8001, 16'h4100, 1'b0);
        // R6 R8 bits already set / all ones
        run_case(32'h0000_000D, 32'h0, 16'h0000, 16'hFFFF, 16'h0000, 1'b0);
        // R11 duplicate start during stall sequence
        run_case(32'h0000_000D, 32'h0, 16'h0000, 16'h0000, 16'h00F0, 1'b1);
        // R11 duplicate start during non-recovery judgement
        run_case(32'h0000_0011, 32'h0, 16'h0000, 16'h0000, 16'h0, 1'b1);

        for (int t = 0; t < 30; t++) begin
            automatic logic [31:0] lo = $urandom();
            automatic logic [31:0] hi = $urandom();
            automatic logic [15:0] st = 16'($urandom());
            if ($urandom_range(0, 1) == 1) lo[5:0] = 6'h0D;
            if ($urandom_range(0, 3) != 0) hi[4] = 1'b0;
            if ($urandom_range(0, 1) == 1) st[0] = 1'b0;
            run_case(lo, hi, st, 16'($urandom()), 16'($urandom()), 1'b0);
        end

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule